// File: doc/BRIEF.md
# GPIO Function-Select and Pull Control

This block is the configuration store for a small bank of general-purpose pins. Software writes a 3-bit function code per pin over a plain 32-bit register bus. The code decides whether the pad drives as an output, stays an input, or hands the pin to an alternate on-chip peripheral. The decoded direction and alternate-select lines go straight to the pad ring. Reads return the full stored word, so software can update one pin's field with a read-modify-write without disturbing its neighbours.

Pull resistors are programmed indirectly, in two steps. A single shared mode register holds the requested pull (off, down or up). A separate per-pin clock register then transfers that mode into only those pins whose clock bit goes from 0 to 1 on a write. Each pin keeps its own latched pull after the shared mode register changes. This lets software set up pins in groups with one shared mode field. The usual sequence is: write the mode, set the target clock bits, then return both registers to zero.

Top module: `gpio_pinmux_ctl`

## Requirements
- R1: After reset every function field, the mode register and the clock register read 0, and all four pad outputs are low for every pin.
- R2: Pin p's 3-bit function field sits in the register at byte offset 4*(p/10), bits 3*(p%10)+2 down to 3*(p%10); pin 14 therefore uses offset 0x04 bits 14:12 and pin 15 uses offset 0x04 bits 17:15.
- R3: Function code 000 gives an input (pad_out_en=0, pad_alt_en=0), 001 gives an output (pad_out_en=1, pad_alt_en=0), and every other code (100 is alternate function 0) gives pad_alt_en=1, pad_out_en=0.
- R4: A function register read returns exactly the stored fields; bits 31:30 and fields of pins at or above NUM_PINS read 0 and ignore writes.
- R5: The pull-mode register at offset 0x94 stores bits 1:0 (00 off, 01 pull-down, 10 pull-up); its other bits read 0.
- R6: The pull-clock register at offset 0x98 holds one bit per pin (bit p for pin p, bits at or above NUM_PINS read 0); a write in which bit p goes from 0 to 1 copies the current mode into pin p, which drives pad_pull_up for 10 and pad_pull_dn for 01.
- R7: A pin's pull does not change while its clock bit stays high or low, nor when the bit falls: mode register writes and rewrites of an already-set bit leave it alone.
- R8: A latched mode of 11 (reserved) leaves the pin with neither pull-up nor pull-down.
- R9: A write to any address other than the function registers, 0x94 and 0x98 (including unaligned ones) changes nothing, and such reads return 0.
- R10: Pad outputs change at the clock edge that accepts the write and are visible in the following cycle; reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_out_en | output | NUM_PINS | Per-pin output driver enable |
| pad_alt_en | output | NUM_PINS | Per-pin alternate-function select |
| pad_pull_up | output | NUM_PINS | Per-pin pull-up enable |
| pad_pull_dn | output | NUM_PINS | Per-pin pull-down enable |

## Verification
The assertions assume that bus_wr, bus_addr and bus_wdata are settled at every rising edge. They also assume a write lasts one cycle per strobe, so a held strobe is a run of repeated writes. The latching properties compare the incoming clock word with the stored clock bits in the same cycle. They therefore assume each write to 0x98 is a separate event. The bench drives every bus input at the falling edge and releases the strobe after one cycle. It also walks the clock bits through rise, hold-high, rewrite and fall, with the mode register changing in between.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    localparam int REG_ADDR_W   = 8;
    localparam int BUS_DATA_W   = 32;
    localparam int FSEL_W       = 3;
    localparam int PINS_PER_REG = 10;
    localparam int FSEL_DATA_W  = FSEL_W * PINS_PER_REG;
    localparam int PULL_W       = 2;

    localparam logic [REG_ADDR_W-1:0] OFS_PULL_MODE = 8'h94;
    localparam logic [REG_ADDR_W-1:0] OFS_PULL_CLK  = 8'h98;

    typedef enum logic [FSEL_W-1:0] {
        FUNC_INPUT  = 3'b000,
        FUNC_OUTPUT = 3'b001,
        FUNC_ALT0   = 3'b100
    } func_e;

    typedef enum logic [PULL_W-1:0] {
        PULL_OFF  = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_UP   = 2'b10,
        PULL_RSVD = 2'b11
    } pull_e;

    typedef struct packed {
        logic out_en;
        logic alt_en;
    } pad_dir_t;

    typedef struct packed {
        logic                  wr;
        logic [REG_ADDR_W-1:0] addr;
        logic [BUS_DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic pad_dir_t decode_func(input logic [FSEL_W-1:0] code);
        pad_dir_t d;
        d.out_en = (code == FUNC_OUTPUT);
        d.alt_en = (code != FUNC_INPUT) && (code != FUNC_OUTPUT);
        return d;
    endfunction

    function automatic pull_e pull_resolve(input logic [PULL_W-1:0] mode);
        pull_e r;
        case (mode)
            2'b01:   r = PULL_DOWN;
            2'b10:   r = PULL_UP;
            default: r = PULL_OFF;
        endcase
        return r;
    endfunction

    function automatic logic [REG_ADDR_W-1:0] fsel_offset(input int reg_idx);
        return REG_ADDR_W'(reg_idx * 4);
    endfunction

endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [REG_ADDR_W-1:0]        addr,
    input  logic [FSEL_DATA_W-1:0]       wdata,
    output logic [NUM_PINS*FSEL_W-1:0]   fsel_flat,
    output logic [NUM_PINS-1:0]          out_en,
    output logic [NUM_PINS-1:0]          alt_en
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int REG_IDX = p / PINS_PER_REG;
        localparam int LSB     = (p % PINS_PER_REG) * FSEL_W;

        logic [FSEL_W-1:0] field_q;
        logic              hit;
        pad_dir_t          dir;

        assign hit = wr_en && (addr == fsel_offset(REG_IDX));

        always_ff @(posedge clk) begin
            if (rst) begin
                field_q <= FUNC_INPUT;
            end else if (hit) begin
                field_q <= wdata[LSB +: FSEL_W];
            end
        end

        assign dir = decode_func(field_q);
        assign fsel_flat[p*FSEL_W +: FSEL_W] = field_q;
        assign out_en[p] = dir.out_en;
        assign alt_en[p] = dir.alt_en;
    end

endmodule

// File: rtl/gpio_pull_latch.sv
module gpio_pull_latch
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [PULL_W-1:0]     mode_wdata,
    input  logic [NUM_PINS-1:0]   clk_wdata,
    output logic [PULL_W-1:0]     mode_q,
    output logic [NUM_PINS-1:0]   pclk_q,
    output logic [NUM_PINS-1:0]   pull_up,
    output logic [NUM_PINS-1:0]   pull_dn
);

    logic                mode_wr;
    logic                clk_wr;
    logic [NUM_PINS-1:0] rise;

    assign mode_wr = wr_en && (addr == OFS_PULL_MODE);
    assign clk_wr  = wr_en && (addr == OFS_PULL_CLK);
    assign rise    = clk_wr ? (clk_wdata & ~pclk_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PULL_OFF;
            pclk_q <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_wdata;
            if (clk_wr)  pclk_q <= clk_wdata;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pull_e state_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q <= PULL_OFF;
            end else if (rise[p]) begin
                state_q <= pull_resolve(mode_q);
            end
        end

        assign pull_up[p] = (state_q == PULL_UP);
        assign pull_dn[p] = (state_q == PULL_DOWN);
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic [REG_ADDR_W-1:0]      addr,
    input  logic [NUM_PINS*FSEL_W-1:0] fsel_flat,
    input  logic [PULL_W-1:0]          mode_q,
    input  logic [NUM_PINS-1:0]        pclk_q,
    output logic [BUS_DATA_W-1:0]      rdata
);

    localparam int NUM_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

    always_comb begin
        rdata = '0;
        if (addr == OFS_PULL_MODE) begin
            rdata[PULL_W-1:0] = mode_q;
        end else if (addr == OFS_PULL_CLK) begin
            rdata[NUM_PINS-1:0] = pclk_q;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr == fsel_offset(r)) begin
                    for (int k = 0; k < PINS_PER_REG; k++) begin
                        if (r * PINS_PER_REG + k < NUM_PINS) begin
                            rdata[k*FSEL_W +: FSEL_W] =
                                fsel_flat[(r*PINS_PER_REG + k)*FSEL_W +: FSEL_W];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_pinmux_ctl.sv
module gpio_pinmux_ctl
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    output logic [NUM_PINS-1:0]   pad_out_en,
    output logic [NUM_PINS-1:0]   pad_alt_en,
    output logic [NUM_PINS-1:0]   pad_pull_up,
    output logic [NUM_PINS-1:0]   pad_pull_dn
);

    bus_req_t                   req;
    logic [NUM_PINS*FSEL_W-1:0] fsel_flat;
    logic [PULL_W-1:0]          pull_mode_q;
    logic [NUM_PINS-1:0]        pull_clk_q;
    logic                       unused_wdata_hi;

    assign req.wr    = bus_wr;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;
    assign unused_wdata_hi = ^req.wdata[BUS_DATA_W-1:FSEL_DATA_W];

    gpio_fsel_bank #(.NUM_PINS(NUM_PINS)) u_fsel (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (req.wr),
        .addr      (req.addr),
        .wdata     (req.wdata[FSEL_DATA_W-1:0]),
        .fsel_flat (fsel_flat),
        .out_en    (pad_out_en),
        .alt_en    (pad_alt_en)
    );

    gpio_pull_latch #(.NUM_PINS(NUM_PINS)) u_pull (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (req.wr),
        .addr       (req.addr),
        .mode_wdata (req.wdata[PULL_W-1:0]),
        .clk_wdata  (req.wdata[NUM_PINS-1:0]),
        .mode_q     (pull_mode_q),
        .pclk_q     (pull_clk_q),
        .pull_up    (pad_pull_up),
        .pull_dn    (pad_pull_dn)
    );

    gpio_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
        .addr      (req.addr),
        .fsel_flat (fsel_flat),
        .mode_q    (pull_mode_q),
        .pclk_q    (pull_clk_q),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/gpio_pinmux_ctl_chk.sv
module gpio_pinmux_ctl_chk
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [NUM_PINS-1:0]   clk_wdata,
    input logic [NUM_PINS-1:0]   pad_out_en,
    input logic [NUM_PINS-1:0]   pad_alt_en,
    input logic [NUM_PINS-1:0]   pad_pull_up,
    input logic [NUM_PINS-1:0]   pad_pull_dn,
    input logic [PULL_W-1:0]     mode_q,
    input logic [NUM_PINS-1:0]   pclk_q
);

    localparam int NUM_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

    logic clk_write;
    logic fsel_write;
    assign clk_write  = bus_wr && (bus_addr == OFS_PULL_CLK);
    assign fsel_write = bus_wr && (bus_addr < REG_ADDR_W'(NUM_REGS * 4));

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pad_out_en == '0 && pad_alt_en == '0 && pad_pull_up == '0
                 && pad_pull_dn == '0 && mode_q == '0 && pclk_q == '0));

    p_dir_excl_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_out_en & pad_alt_en) == '0);

    p_fsel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !fsel_write |=> ($stable(pad_out_en) && $stable(pad_alt_en)));

    p_pull_excl_r6: assert property (@(posedge clk) disable iff (rst)
        (pad_pull_up & pad_pull_dn) == '0);

    p_pull_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !clk_write |=> ($stable(pad_pull_up) && $stable(pad_pull_dn)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        p_latch_up_r6: assert property (@(posedge clk) disable iff (rst)
            (clk_write && clk_wdata[p] && !pclk_q[p] && mode_q == 2'b10)
            |=> (pad_pull_up[p] && !pad_pull_dn[p]));

        p_latch_dn_r6: assert property (@(posedge clk) disable iff (rst)
            (clk_write && clk_wdata[p] && !pclk_q[p] && mode_q == 2'b01)
            |=> (pad_pull_dn[p] && !pad_pull_up[p]));

        p_latch_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
            (clk_write && clk_wdata[p] && !pclk_q[p] && mode_q == 2'b11)
            |=> (!pad_pull_up[p] && !pad_pull_dn[p]));

        p_held_bit_r7: assert property (@(posedge clk) disable iff (rst)
            (clk_write && pclk_q[p])
            |=> ($stable(pad_pull_up[p]) && $stable(pad_pull_dn[p])));
    end

endmodule

bind gpio_pinmux_ctl gpio_pinmux_ctl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .clk_wdata   (bus_wdata[NUM_PINS-1:0]),
    .pad_out_en  (pad_out_en),
    .pad_alt_en  (pad_alt_en),
    .pad_pull_up (pad_pull_up),
    .pad_pull_dn (pad_pull_dn),
    .mode_q      (pull_mode_q),
    .pclk_q      (pull_clk_q)
);

// File: tb/gpio_pinmux_ctl_bench.sv
module gpio_pinmux_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 20;
    localparam int NREG = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_out_en, pad_alt_en, pad_pull_up, pad_pull_dn;

    int n_checks = 0;
    int n_errs = 0;
    bit live = 1'b0;

    int fsel_m [NP];
    int pull_m [NP];
    int mode_m = 0;
    logic [31:0] clk_m = '0;

    gpio_pinmux_ctl #(.NUM_PINS(NP)) u_gpio_pinmux_ctl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_out_en(pad_out_en), .pad_alt_en(pad_alt_en),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model of a single accepted write.
    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h94) begin
            mode_m = int'(d[1:0]);
        end else if (a == 8'h98) begin
            for (int p = 0; p < NP; p++)
                if (d[p] && !clk_m[p]) pull_m[p] = (mode_m == 3) ? 0 : mode_m;
            clk_m = d & ((32'd1 << NP) - 1);
        end else if (a[1:0] == 2'b00 && int'(a >> 2) < NREG) begin
            for (int k = 0; k < 10; k++) begin
                int p = int'(a >> 2) * 10 + k;
                if (p < NP) fsel_m[p] = int'((d >> (3*k)) & 32'h7);
            end
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h94) r = 32'(mode_m);
        else if (a == 8'h98) r = clk_m;
        else if (a[1:0] == 2'b00 && int'(a >> 2) < NREG) begin
            for (int k = 0; k < 10; k++) begin
                int p = int'(a >> 2) * 10 + k;
                if (p < NP) r = r | (32'(fsel_m[p]) << (3*k));
            end
        end
        return r;
    endfunction

    // Per-cycle comparison of all pad outputs against the model (R3, R6, R10).
    always @(negedge clk) begin
        if (live) begin
            logic [31:0] e_oe, e_alt, e_up, e_dn;
            e_oe = '0; e_alt = '0; e_up = '0; e_dn = '0;
            for (int p = 0; p < NP; p++) begin
                e_oe[p]  = (fsel_m[p] == 1);
                e_alt[p] = (fsel_m[p] > 1);
                e_up[p]  = (pull_m[p] == 2);
                e_dn[p]  = (pull_m[p] == 1);
            end
            chk("R3 pad_out_en", 32'(pad_out_en), e_oe);
            chk("R3 pad_alt_en", 32'(pad_alt_en), e_alt);
            chk("R6 pad_pull_up", 32'(pad_pull_up), e_up);
            chk("R6 pad_pull_dn", 32'(pad_pull_dn), e_dn);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, model_read(a));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin fsel_m[p] = 0; pull_m[p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R1: reset values
        rd("R1 fsel0", 8'h00);
        rd("R1 fsel1", 8'h04);
        rd("R1 mode", 8'h94);
        rd("R1 pclk", 8'h98);

        // R2: pins 14 and 15 to alternate function 0
        wr(8'h04, 32'h0002_4000);
        rd("R2 fsel1 pins14_15", 8'h04);
        chk("R2 pin14 alt", 32'(pad_alt_en[14]), 32'd1);
        chk("R2 pin15 alt", 32'(pad_alt_en[15]), 32'd1);

        // R4: read-modify-write keeps neighbours
        @(negedge clk); bus_addr = 8'h04; #1;
        wr(8'h04, bus_rdata | 32'h1);
        rd("R4 rmw fsel1", 8'h04);

        // R3: codes output, alternates
        wr(8'h00, 32'h1 | (32'd3 << 3) | (32'd5 << 6) | (32'd7 << 9));
        rd("R3 fsel0", 8'h00);
        chk("R3 pin0 output", 32'(pad_out_en[0]), 32'd1);

        // R4: unused bits read zero
        wr(8'h04, 32'hFFFF_FFFF);
        rd("R4 fsel1 all ones", 8'h04);
        chk("R4 fsel1 bits31_30", bus_rdata[31:30], 32'd0);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0002_4000);

        // R9: unmapped and unaligned writes
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h9C, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h96, 32'hFFFF_FFFF);
        rd("R9 unmapped 0x08", 8'h08);
        rd("R9 unmapped 0x9C", 8'h9C);
        rd("R9 fsel1 untouched", 8'h04);
        rd("R9 mode untouched", 8'h94);

        // R5: mode register
        wr(8'h94, 32'hFF);
        rd("R5 mode bits", 8'h94);
        wr(8'h94, 32'h2);

        // R6: latch pull-up on pins 14 and 15
        wr(8'h98, 32'h0000_C000);
        rd("R6 pclk", 8'h98);
        chk("R6 pin14 up", 32'(pad_pull_up[14]), 32'd1);

        // R7: mode change and held / rewritten / falling bits
        wr(8'h94, 32'h1);
        chk("R7 pin15 still up", 32'(pad_pull_up[15]), 32'd1);
        wr(8'h98, 32'h0000_C000);
        chk("R7 rewrite keeps up", 32'(pad_pull_up[14]), 32'd1);
        wr(8'h98, 32'h0);
        chk("R7 fall keeps up", 32'(pad_pull_up[14]), 32'd1);

        // R6: pull-down on pin 3
        wr(8'h98, 32'h8);
        chk("R6 pin3 down", 32'(pad_pull_dn[3]), 32'd1);

        // R8: reserved mode
        wr(8'h94, 32'h3);
        wr(8'h98, 32'h0000_4008);
        chk("R8 pin14 no pull", 32'({pad_pull_up[14], pad_pull_dn[14]}), 32'd0);
        chk("R7 pin3 held high", 32'(pad_pull_dn[3]), 32'd1);
        wr(8'h98, 32'hFFFF_FFFF);
        rd("R6 pclk width", 8'h98);

        // R6: all pins pull-up via a fresh rise
        wr(8'h94, 32'h2);
        wr(8'h98, 32'h0);
        wr(8'h98, 32'h000F_FFFF);
        chk("R6 all up", 32'(pad_pull_up), 32'h000F_FFFF);
        wr(8'h94, 32'h0);
        wr(8'h98, 32'h0);
        rd("R5 mode cleared", 8'h94);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule